// File: doc/BRIEF.md
# Strobed Byte-Wide Register Port

This block lets a host processor reach a small file of four byte-wide registers through a classic strobed bus. The bus has an active-low read strobe, an active-low write strobe, a 2-bit register select and a bidirectional data bus. The strobes come from outside the system clock domain. Each one passes through a synchronizer, and the port then works on the synchronized falling and rising edges. The data bus is presented as separate input, output-data and output-enable signals. A pad wrapper joins them into a tri-state pin.

A falling strobe edge captures the register select. That captured select stays in force until the strobe rises again, even if the select lines move in the meantime. A write commits the bus byte on the rising write edge. A read drives the bus for as long as the read strobe stays low, and the bus is released once the strobe rises. A narrow-colour mode restricts the colour-data register (select value 1) to six bits. Strobes that overlap are treated as a protocol error.

Top module: `mpu_regport`

## Requirements
- R1: The register select is captured when a falling edge of either strobe is detected. It is held until the matching rising edge, so a change of `sel` while the strobe is low does not change which register is read or written.
- R2: When the write strobe rises, the byte on `bus_in` is stored in the captured register. It is readable in the next read transaction.
- R3: Three clock edges after `rd_n` falls, `bus_oe` is 1 and `bus_out` carries the captured register's value. Both stay that way while `rd_n` stays low.
- R4: By the third clock edge after `rd_n` rises, `bus_oe` is 0 and the bus is released. `bus_out` is 0x00 whenever `bus_oe` is 0.
- R5: With `narrow_mode`=1, a write to register 1 stores only bits 5:0 of `bus_in`. Bits 7:6 of the stored value become 0.
- R6: With `narrow_mode`=1, a read of register 1 returns bits 7:6 as 0, even if the register was written in full while `narrow_mode` was 0.
- R7: `narrow_mode` has no effect on registers 0, 2 and 3, which keep and return all 8 bits.
- R8: Synchronous active-high `rst` clears all four registers to 0x00 and deasserts `bus_oe`.
- R9: If both strobes are low at the same time, the transaction is aborted. No register is written and `bus_oe` goes to 0. The port stays idle until both strobes are high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| sel | input | 2 | Register select, sampled on the falling strobe edge |
| narrow_mode | input | 1 | 1 = colour register limited to 6 bits |
| bus_in | input | 8 | Data bus value from the pad |
| bus_out | output | 8 | Data driven towards the pad |
| bus_oe | output | 1 | Pad output enable, 1 = drive |

## Verification
A corrupted register or a wrongly captured select only shows up the next time that register is read back. The bench therefore follows every write with a readback of all four registers, and a stray write to a neighbour is caught in the same sweep. Faults in the transaction state machine show on `bus_oe`, which is checked three edges after each strobe edge. A missing abort shows as a driven bus during overlapping strobes, or as an overwritten register on the next read.

// File: rtl/mpu_regport_pkg.sv
package mpu_regport_pkg;

  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_READ  = 2'd1,
    XF_WRITE = 2'd2,
    XF_ABORT = 2'd3
  } xfer_state_t;

endpackage

// File: rtl/mpu_strobe_sync.sv
module mpu_strobe_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out,
  output logic [WIDTH-1:0] sync_prev
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gen_stage
      if (g == 0) begin : gen_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '1;
          else     chain[g] <= async_in;
        end
      end else begin : gen_rest
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) sync_prev <= '1;
    else     sync_prev <= chain[STAGES-1];
  end

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/mpu_regfile.sv
module mpu_regfile #(
  parameter int DATA_W    = 8,
  parameter int SEL_W     = 2,
  parameter int COLOR_SEL = 1,
  parameter int NARROW_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEL_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wnarrow,
  input  logic [SEL_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << SEL_W;
  localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [SEL_W-1:0] COLOR_ADDR = SEL_W'(COLOR_SEL);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] store_val;

  always_comb begin
    store_val = wdata;
    if (wnarrow && waddr == COLOR_ADDR) store_val = wdata & NARROW_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= store_val;
    end
  end

  assign rdata = mem[raddr];

  assert_narrow_store_R5: assert property (@(posedge clk) disable iff (rst)
    (we && wnarrow && waddr == COLOR_ADDR) |=> ((mem[COLOR_ADDR] & ~NARROW_MASK) == '0));

endmodule

// File: rtl/mpu_xfer_ctrl.sv
module mpu_xfer_ctrl
  import mpu_regport_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SEL_W     = 2,
  parameter int COLOR_SEL = 1,
  parameter int NARROW_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_s,
  input  logic              wr_s,
  input  logic              rd_prev,
  input  logic              wr_prev,
  input  logic [SEL_W-1:0]  sel_in,
  input  logic              narrow_mode,
  input  logic [DATA_W-1:0] bus_in,
  input  logic [DATA_W-1:0] rdata,
  output logic [SEL_W-1:0]  raddr,
  output logic              we,
  output logic [SEL_W-1:0]  waddr,
  output logic [DATA_W-1:0] wdata,
  output logic              wnarrow,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_out
);

  localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [SEL_W-1:0] COLOR_ADDR = SEL_W'(COLOR_SEL);

  xfer_state_t state_q, state_d;
  logic [SEL_W-1:0] sel_q;
  logic rd_fall, wr_fall, rd_rise, wr_rise, clash;
  logic [DATA_W-1:0] read_val;

  assign rd_fall = rd_prev & ~rd_s;
  assign wr_fall = wr_prev & ~wr_s;
  assign rd_rise = ~rd_prev & rd_s;
  assign wr_rise = ~wr_prev & wr_s;
  assign clash   = ~rd_s & ~wr_s;

  assign raddr = (state_q == XF_IDLE) ? sel_in : sel_q;

  always_comb begin
    read_val = rdata;
    if (narrow_mode && raddr == COLOR_ADDR) read_val = rdata & NARROW_MASK;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      XF_IDLE: begin
        if (clash)        state_d = XF_ABORT;
        else if (rd_fall) state_d = XF_READ;
        else if (wr_fall) state_d = XF_WRITE;
      end
      XF_READ: begin
        if (!wr_s)        state_d = XF_ABORT;
        else if (rd_rise) state_d = XF_IDLE;
      end
      XF_WRITE: begin
        if (!rd_s)        state_d = XF_ABORT;
        else if (wr_rise) state_d = XF_IDLE;
      end
      XF_ABORT: begin
        if (rd_s && wr_s) state_d = XF_IDLE;
      end
      default: state_d = XF_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= XF_IDLE;
      sel_q   <= '0;
      we      <= 1'b0;
      waddr   <= '0;
      wdata   <= '0;
      wnarrow <= 1'b0;
      bus_oe  <= 1'b0;
      bus_out <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == XF_IDLE && (rd_fall || wr_fall)) sel_q <= sel_in;
      we <= (state_q == XF_WRITE) && (state_d == XF_IDLE);
      if (state_q == XF_WRITE) begin
        waddr   <= sel_q;
        wdata   <= bus_in;
        wnarrow <= narrow_mode;
      end
      bus_oe  <= (state_d == XF_READ);
      bus_out <= (state_d == XF_READ) ? read_val : '0;
    end
  end

  assert_clash_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    clash |=> (!bus_oe && !we));

  assert_idle_bus_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> (bus_out == '0));

endmodule

// File: rtl/mpu_regport.sv
module mpu_regport #(
  parameter int DATA_W      = 8,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int COLOR_SEL   = 1,
  parameter int NARROW_W    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [SEL_W-1:0]  sel,
  input  logic              narrow_mode,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe
);

  logic [1:0] strobe_s, strobe_p;
  logic [SEL_W-1:0] raddr, waddr;
  logic [DATA_W-1:0] rdata, wdata;
  logic we, wnarrow;

  mpu_strobe_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .async_in({wr_n, rd_n}),
    .sync_out(strobe_s), .sync_prev(strobe_p)
  );

  mpu_xfer_ctrl #(.DATA_W(DATA_W), .SEL_W(SEL_W), .COLOR_SEL(COLOR_SEL), .NARROW_W(NARROW_W)) ctrl_i (
    .clk(clk), .rst(rst),
    .rd_s(strobe_s[0]), .wr_s(strobe_s[1]), .rd_prev(strobe_p[0]), .wr_prev(strobe_p[1]),
    .sel_in(sel), .narrow_mode(narrow_mode), .bus_in(bus_in), .rdata(rdata),
    .raddr(raddr), .we(we), .waddr(waddr), .wdata(wdata), .wnarrow(wnarrow),
    .bus_oe(bus_oe), .bus_out(bus_out)
  );

  mpu_regfile #(.DATA_W(DATA_W), .SEL_W(SEL_W), .COLOR_SEL(COLOR_SEL), .NARROW_W(NARROW_W)) rf_i (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata), .wnarrow(wnarrow),
    .raddr(raddr), .rdata(rdata)
  );

  assert_drive_only_in_read_R3: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> !strobe_p[0]);

  assert_release_after_read_R4: assert property (@(posedge clk) disable iff (rst)
    (!strobe_p[0] && strobe_s[0]) |=> !bus_oe);

  assert_no_write_during_read_R9: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> !we);

endmodule

// File: tb/mpu_regport_tb_top.sv
`timescale 1ns/1ps
module mpu_regport_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_n = 1'b1, wr_n = 1'b1, narrow_mode = 1'b0;
  logic [1:0] sel = '0;
  logic [7:0] bus_in = '0;
  logic [7:0] bus_out;
  logic bus_oe;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] model [4];

  always #4 clk = ~clk;

  mpu_regport dut_i (
    .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .sel(sel),
    .narrow_mode(narrow_mode), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] s, input logic [7:0] d, input bit move_sel);
    sel = s; bus_in = d;
    tick(1);
    wr_n = 1'b0;
    tick(4);
    if (move_sel) sel = ~s;
    tick(2);
    wr_n = 1'b1;
    tick(5);
    model[s] = (narrow_mode && s == 2'd1) ? (d & 8'h3F) : d;
  endtask

  task automatic do_read(input logic [1:0] s, input string req);
    logic [7:0] exp;
    exp = (narrow_mode && s == 2'd1) ? (model[s] & 8'h3F) : model[s];
    sel = s;
    tick(1);
    rd_n = 1'b0;
    tick(3);
    check(req, {bus_oe, bus_out}, {1'b1, exp});
    sel = ~s;
    tick(3);
    check({req, "/R1 held select"}, {bus_oe, bus_out}, {1'b1, exp});
    rd_n = 1'b1;
    tick(3);
    check("R4 release", {bus_oe, bus_out}, 9'h000);
    tick(1);
  endtask

  task automatic read_all(input string req);
    for (int k = 0; k < 4; k++) do_read(2'(k), req);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      begin
        for (int k = 0; k < 4; k++) model[k] = 8'h00;
        tick(3);
        rst = 1'b0;
        tick(2);
        check("R8 reset oe", {bus_oe, bus_out}, 9'h000);
        read_all("R8 reset value");

        for (int m = 0; m < 2; m++) begin
          narrow_mode = m[0];
          for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 4; p++) begin
              logic [7:0] d;
              d = 8'(8'hC3 ^ (p * 8'h5B) ^ (s * 8'h11));
              do_write(2'(s), d, p[0]);
              if (s == 1 && m == 1) read_all("R5 narrow write");
              else if (s == 1)      read_all("R2 write");
              else                  read_all("R7 full width");
            end
          end
        end

        narrow_mode = 1'b0;
        do_write(2'd1, 8'hFF, 1'b0);
        narrow_mode = 1'b1;
        do_read(2'd1, "R6 narrow read");
        narrow_mode = 1'b0;
        do_read(2'd1, "R6 full read");
        do_write(2'd2, 8'hE7, 1'b0);
        do_write(2'd0, 8'h81, 1'b0);
        narrow_mode = 1'b1;
        do_read(2'd2, "R7 reg2 narrow");
        do_read(2'd0, "R7 reg0 narrow");
        narrow_mode = 1'b0;

        sel = 2'd2; bus_in = 8'h18;
        tick(1);
        wr_n = 1'b0; rd_n = 1'b0;
        tick(4);
        check("R9 no drive on clash", {8'h00, bus_oe}, 9'h000);
        wr_n = 1'b1; rd_n = 1'b1;
        tick(6);
        do_read(2'd2, "R9 clash no write");

        sel = 2'd3; bus_in = 8'h42;
        tick(1);
        wr_n = 1'b0;
        tick(4);
        rd_n = 1'b0;
        tick(3);
        wr_n = 1'b1;
        tick(4);
        check("R9 abort held", {8'h00, bus_oe}, 9'h000);
        rd_n = 1'b1;
        tick(6);
        do_read(2'd3, "R9 late clash no write");

        sel = 2'd0;
        tick(1);
        rd_n = 1'b0;
        tick(4);
        wr_n = 1'b0;
        tick(3);
        check("R9 read cut", {8'h00, bus_oe}, 9'h000);
        wr_n = 1'b1; rd_n = 1'b1;
        tick(6);
        read_all("R9 after cut read");

        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) model[k] = 8'h00;
        tick(2);
        read_all("R8 mid-run reset");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule